// File: doc/BRIEF.md
# Boundary-Mode Switch Timing Generator

This block drives the gate of one boost power stage that runs in boundary conduction mode. A charging pass starts from rest with an immediate on-phase. After that, each new cycle waits for the inductor current to return to zero. When a zero crossing is detected, the block waits out the resonant swing of the snubber network before it closes the switch again. The length of that wait comes from a small table. The table is indexed by an operating-point code, which is captured at the crossing.

The on-phase ends when an external peak-current comparator trips. If the trip never arrives, an on-time ceiling forces the switch open and latches a fault. Because every cycle is self-contained, the block can stop cleanly at the end of any cycle. It stops when charging is disabled or when the measured output voltage has reached its target, and in the second case it flags the pass as finished.

All inputs are synchronous digital flags, except the zero-crossing flag, which is re-timed internally. A one-cycle strobe marks every turn-on for downstream logic.

Top module: `bcm_gate_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `gate_o`, `cyc_start_o`, `ocp_fault_o` and `done_o` are all 0.
- R2: At rest, the first clock edge that sees `run_en`=1, `vout_reached`=0 and no latched fault raises `gate_o`, together with a one-cycle `cyc_start_o`.
- R3: `op_code` is captured in the cycle a zero crossing is accepted, and later changes of `op_code` do not alter that cycle's delay.
- R4: `zc_in` passes two synchronising flip-flops and is edge-detected. If `zc_in` first reads 1 at clock edge k while the block waits for a crossing, then `gate_o` rises at edge k+D+3, where D = `DLY_BASE` + `op_code`*`DLY_STEP`.
- R5: A rising `zc_in` seen during the resonant delay, the on-phase or the off blanking is ignored.
- R6: A clock edge that sees `pk_trip`=1 while `gate_o` is high drives `gate_o` low from that edge.
- R7: If no trip arrives, `gate_o` stays high for exactly `MAX_ON` cycles, then falls, and `ocp_fault_o` becomes 1. When a trip and the ceiling fall on the same edge, the trip wins and no fault is raised.
- R8: Once set, `ocp_fault_o` stays 1 until reset, and no new cycle starts while it is set.
- R9: After every turn-off, `gate_o` stays low for at least `BLANK`+1 cycles. Crossings are not looked for during the first `BLANK` of them.
- R10: With `run_en`=0 or `vout_reached`=1, no new cycle begins. The block returns to rest while waiting for a crossing, at the end of blanking, or during the resonant delay (that cycle is abandoned). An on-phase already running is never cut short.
- R11: `done_o` goes to 1 whenever the block declines to start or continue because `vout_reached`=1. It returns to 0 only when a cycle starts from rest.
- R12: `cyc_start_o` is 1 exactly in the first cycle of every on-phase, whether that on-phase started from rest or after a crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Charging allowed; low stops at the next cycle boundary |
| vout_reached | input | 1 | Output voltage at or above target |
| zc_in | input | 1 | Inductor-current zero-crossing flag (re-timed inside) |
| op_code | input | CODE_W | Operating-point code, indexes the delay table |
| pk_trip | input | 1 | Peak-current comparator trip |
| gate_o | output | 1 | Switch gate command |
| cyc_start_o | output | 1 | One-cycle strobe at each turn-on |
| ocp_fault_o | output | 1 | Sticky on-time ceiling fault |
| done_o | output | 1 | Charging pass finished |

## Verification
The bench builds the block with `DLY_BASE`=2, `DLY_STEP`=3, `MAX_ON`=30 and `BLANK`=4. These values keep every table delay under fifty cycles, so a short run can reach the on-time ceiling, the end of blanking and the deepest table entry (code 15, 47 ticks). They also make crossing pulses easy to place inside the blanking and delay windows, to show that those pulses are ignored. A behavioural model driven by the same inputs predicts all four outputs on every clock, and directed checks time the delay from a crossing to turn-on for several codes.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ZC,
    ST_RES_DLY,
    ST_ON,
    ST_OFF_WAIT
  } bcm_state_e;

  // delay table entry: linear in the operating-point code
  function automatic int unsigned dly_entry(int unsigned base, int unsigned step, int unsigned idx);
    return base + step * idx;
  endfunction

endpackage

// File: rtl/bcm_zc_sync.sv
module bcm_zc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic zc_in,
  output logic zc_edge
);

  // sh[STAGES-1] is the re-timed level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], zc_in};
  end

  assign zc_edge = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/bcm_delay_rom.sv
module bcm_delay_rom #(
  parameter int CODE_W   = 4,
  parameter int DLY_W    = 12,
  parameter int DLY_BASE = 24,
  parameter int DLY_STEP = 8
) (
  input  logic              clk,
  input  logic [CODE_W-1:0] addr,
  output logic [DLY_W-1:0]  data
);

  localparam int DEPTH = 1 << CODE_W;

  logic [DLY_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = DLY_W'(bcm_pkg::dly_entry(DLY_BASE, DLY_STEP, i));
  end

  // registered read so the table maps onto a block memory
  always_ff @(posedge clk) data <= mem[addr];

endmodule

// File: rtl/bcm_fsm.sv
module bcm_fsm
  import bcm_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int DLY_W  = 12,
  parameter int MAX_ON = 1500,
  parameter int BLANK  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              vout_reached,
  input  logic              zc_edge,
  input  logic [CODE_W-1:0] op_code,
  input  logic              pk_trip,
  input  logic [DLY_W-1:0]  dly_val,
  output logic [CODE_W-1:0] code_q,
  output logic              gate_o,
  output logic              cyc_start_o,
  output logic              ocp_fault_o,
  output logic              done_o
);

  localparam int ON_W = $clog2(MAX_ON + 1);
  localparam logic [ON_W-1:0]  ON_LAST  = ON_W'(MAX_ON - 1);
  localparam logic [DLY_W-1:0] BLK_LAST = DLY_W'(BLANK - 1);

  bcm_state_e       state;
  logic [DLY_W-1:0] cnt;
  logic [ON_W-1:0]  on_cnt;
  logic             halt;

  assign halt = ~run_en | vout_reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      on_cnt      <= '0;
      code_q      <= '0;
      gate_o      <= 1'b0;
      cyc_start_o <= 1'b0;
      ocp_fault_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      cyc_start_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (run_en && vout_reached) begin
            done_o <= 1'b1;
          end else if (run_en && !ocp_fault_o) begin
            state       <= ST_ON;
            gate_o      <= 1'b1;
            cyc_start_o <= 1'b1;
            done_o      <= 1'b0;
            on_cnt      <= '0;
          end
        end
        ST_WAIT_ZC: begin
          if (halt) begin
            state <= ST_IDLE;
            if (vout_reached) done_o <= 1'b1;
          end else if (zc_edge) begin
            state  <= ST_RES_DLY;
            code_q <= op_code;
            cnt    <= '0;
          end
        end
        ST_RES_DLY: begin
          if (halt) begin
            state <= ST_IDLE;
            if (vout_reached) done_o <= 1'b1;
          end else if (cnt != '0 && cnt >= dly_val) begin
            state       <= ST_ON;
            gate_o      <= 1'b1;
            cyc_start_o <= 1'b1;
            on_cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ON: begin
          if (pk_trip) begin
            state  <= ST_OFF_WAIT;
            gate_o <= 1'b0;
            cnt    <= '0;
          end else if (on_cnt == ON_LAST) begin
            state       <= ST_OFF_WAIT;
            gate_o      <= 1'b0;
            cnt         <= '0;
            ocp_fault_o <= 1'b1;
          end else begin
            on_cnt <= on_cnt + 1'b1;
          end
        end
        ST_OFF_WAIT: begin
          if (cnt == BLK_LAST) begin
            if (halt || ocp_fault_o) begin
              state <= ST_IDLE;
              if (vout_reached) done_o <= 1'b1;
            end else begin
              state <= ST_WAIT_ZC;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bcm_gate_timer.sv
module bcm_gate_timer #(
  parameter int CODE_W      = 4,
  parameter int DLY_W       = 12,
  parameter int DLY_BASE    = 24,
  parameter int DLY_STEP    = 8,
  parameter int MAX_ON      = 1500,
  parameter int BLANK       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              vout_reached,
  input  logic              zc_in,
  input  logic [CODE_W-1:0] op_code,
  input  logic              pk_trip,
  output logic              gate_o,
  output logic              cyc_start_o,
  output logic              ocp_fault_o,
  output logic              done_o
);

  logic              zc_edge;
  logic [CODE_W-1:0] code_q;
  logic [DLY_W-1:0]  dly_val;

  bcm_zc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .zc_in   (zc_in),
    .zc_edge (zc_edge)
  );

  bcm_delay_rom #(
    .CODE_W   (CODE_W),
    .DLY_W    (DLY_W),
    .DLY_BASE (DLY_BASE),
    .DLY_STEP (DLY_STEP)
  ) u_rom (
    .clk  (clk),
    .addr (code_q),
    .data (dly_val)
  );

  bcm_fsm #(
    .CODE_W (CODE_W),
    .DLY_W  (DLY_W),
    .MAX_ON (MAX_ON),
    .BLANK  (BLANK)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .run_en       (run_en),
    .vout_reached (vout_reached),
    .zc_edge      (zc_edge),
    .op_code      (op_code),
    .pk_trip      (pk_trip),
    .dly_val      (dly_val),
    .code_q       (code_q),
    .gate_o       (gate_o),
    .cyc_start_o  (cyc_start_o),
    .ocp_fault_o  (ocp_fault_o),
    .done_o       (done_o)
  );

endmodule

// File: rtl/bcm_gate_timer_chk.sv
module bcm_gate_timer_chk #(
  parameter int MAX_ON = 1500,
  parameter int BLANK  = 6
) (
  input logic clk,
  input logic rst,
  input logic gate,
  input logic cyc_start,
  input logic fault,
  input logic done,
  input logic pk_trip
);

  logic [31:0] hi_cnt;
  logic [31:0] lo_cnt;
  logic        gate_d;
  logic        seen_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      gate_d    <= 1'b0;
      seen_fall <= 1'b0;
    end else begin
      gate_d <= gate;
      if (gate) begin
        hi_cnt <= hi_cnt + 1;
        lo_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt < 32'hFFFF) lo_cnt <= lo_cnt + 1;
      end
      if (gate_d && !gate) seen_fall <= 1'b1;
      p_max_on_r7: assert (hi_cnt <= 32'(MAX_ON))
        else $error("on-phase longer than ceiling");
      if (gate && !gate_d && seen_fall)
        p_blank_r9: assert (lo_cnt >= 32'(BLANK + 1))
          else $error("off time shorter than blanking");
    end
  end

  p_trip_off_r6: assert property (@(posedge clk) disable iff (rst)
    (gate && pk_trip) |=> !gate);

  p_rise_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> cyc_start);

  p_strobe_gate_r2: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> gate);

  p_fault_hold_r8: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  p_fault_nostart_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> !cyc_start);

  p_done_off_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !gate);

endmodule

bind bcm_gate_timer bcm_gate_timer_chk #(
  .MAX_ON (MAX_ON),
  .BLANK  (BLANK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gate      (gate_o),
  .cyc_start (cyc_start_o),
  .fault     (ocp_fault_o),
  .done      (done_o),
  .pk_trip   (pk_trip)
);

// File: tb/bcm_gate_timer_test.sv
`timescale 1ns/1ps
module bcm_gate_timer_test;

  localparam int CW = 4;
  localparam int DB = 2;
  localparam int DS = 3;
  localparam int MO = 30;
  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic vout_reached = 1'b0;
  logic zc_in = 1'b0;
  logic [CW-1:0] op_code = '0;
  logic pk_trip = 1'b0;
  logic gate_o, cyc_start_o, ocp_fault_o, done_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bcm_gate_timer #(
    .CODE_W(CW), .DLY_W(12), .DLY_BASE(DB), .DLY_STEP(DS),
    .MAX_ON(MO), .BLANK(BL), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst(rst), .run_en(run_en), .vout_reached(vout_reached),
    .zc_in(zc_in), .op_code(op_code), .pk_trip(pk_trip),
    .gate_o(gate_o), .cyc_start_o(cyc_start_o),
    .ocp_fault_o(ocp_fault_o), .done_o(done_o)
  );

  function automatic int dly(int c);
    return DB + DS * c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // behavioural reference: phase 0 rest, 1 await crossing, 2 delay, 3 on, 4 blank
  int m_ph, m_cnt, m_on, m_code;
  bit m_z1, m_z2, m_z3, m_gate, m_cs, m_fault, m_done;

  always @(posedge clk) begin
    bit zc_rise, stop;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_on = 0; m_code = 0;
      m_z1 = 0; m_z2 = 0; m_z3 = 0;
      m_gate = 0; m_cs = 0; m_fault = 0; m_done = 0;
    end else begin
      zc_rise = m_z2 && !m_z3;
      stop = !run_en || vout_reached;
      m_cs = 0;
      case (m_ph)
        0: if (run_en && vout_reached) m_done = 1;
           else if (run_en && !m_fault) begin
             m_ph = 3; m_gate = 1; m_cs = 1; m_done = 0; m_on = 0;
           end
        1: if (stop) begin m_ph = 0; if (vout_reached) m_done = 1; end
           else if (zc_rise) begin m_ph = 2; m_code = int'(op_code); m_cnt = 0; end
        2: if (stop) begin m_ph = 0; if (vout_reached) m_done = 1; end
           else if (m_cnt >= 1 && m_cnt >= dly(m_code)) begin
             m_ph = 3; m_gate = 1; m_cs = 1; m_on = 0;
           end else m_cnt++;
        3: if (pk_trip) begin m_ph = 4; m_gate = 0; m_cnt = 0; end
           else if (m_on == MO - 1) begin m_ph = 4; m_gate = 0; m_cnt = 0; m_fault = 1; end
           else m_on++;
        default: if (m_cnt == BL - 1) begin
             if (stop || m_fault) begin m_ph = 0; if (vout_reached) m_done = 1; end
             else m_ph = 1;
           end else m_cnt++;
      endcase
      m_z3 = m_z2; m_z2 = m_z1; m_z1 = zc_in;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(gate_o == m_gate, "R4 gate vs model", gate_o, m_gate);
      chk(cyc_start_o == m_cs, "R12 strobe vs model", cyc_start_o, m_cs);
      chk(ocp_fault_o == m_fault, "R7 fault vs model", ocp_fault_o, m_fault);
      chk(done_o == m_done, "R11 done vs model", done_o, m_done);
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      summary();
    end
  end

  task automatic trip_now();
    pk_trip = 1'b1;
    step();
    pk_trip = 1'b0;
  endtask

  task automatic time_to_gate(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!gate_o && n < 300);
  endtask

  initial begin
    int n;
    bit seen;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk({gate_o, cyc_start_o, ocp_fault_o, done_o} == 4'b0, "R1 outputs after reset",
        {gate_o, cyc_start_o, ocp_fault_o, done_o}, 0);

    // R2 start from rest
    run_en = 1'b1;
    step();
    chk(gate_o && cyc_start_o, "R2 first turn-on", {gate_o, cyc_start_o}, 3);
    step();
    chk(gate_o && !cyc_start_o, "R2 strobe one cycle", {gate_o, cyc_start_o}, 2);
    repeat (5) step();
    pk_trip = 1'b1;
    step();
    chk(!gate_o, "R6 trip opens switch", gate_o, 0);
    pk_trip = 1'b0;

    // R9 / R5: crossing inside blanking is ignored
    zc_in = 1'b1;
    repeat (25) step();
    chk(!gate_o, "R9 crossing in blanking ignored", gate_o, 0);
    zc_in = 1'b0;
    repeat (3) step();

    // R4 delay timing, code 5
    op_code = 4'd5;
    zc_in = 1'b1;
    time_to_gate(n);
    chk(n == dly(5) + 4, "R4 delay code 5", n, dly(5) + 4);
    zc_in = 1'b0;
    repeat (3) step();
    trip_now();
    repeat (8) step();

    // R3 code capture, R5 extra crossing during delay
    op_code = 4'd2;
    zc_in = 1'b1;
    repeat (3) step();
    op_code = 4'd15;
    zc_in = 1'b0;
    repeat (2) step();
    zc_in = 1'b1;
    time_to_gate(n);
    n += 5;
    chk(n == dly(2) + 4, "R3 code held at crossing", n, dly(2) + 4);
    chk(n == dly(2) + 4, "R5 crossing during delay ignored", n, dly(2) + 4);
    zc_in = 1'b0;
    repeat (2) step();
    trip_now();
    repeat (8) step();

    // R7 on-time ceiling
    op_code = 4'd0;
    zc_in = 1'b1;
    time_to_gate(n);
    zc_in = 1'b0;
    n = 1;
    while (gate_o && n < 200) begin
      step();
      if (gate_o) n++;
    end
    chk(n == MO, "R7 on cycles at ceiling", n, MO);
    chk(ocp_fault_o, "R7 fault raised", ocp_fault_o, 1);

    // R8 fault blocks new cycles
    repeat (8) step();
    zc_in = 1'b1;
    repeat (3) step();
    zc_in = 1'b0;
    seen = 0;
    repeat (60) begin
      step();
      seen |= gate_o;
    end
    chk(!seen, "R8 no cycle after fault", seen, 0);
    chk(ocp_fault_o, "R8 fault sticky", ocp_fault_o, 1);

    run_en = 1'b0;
    rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    step();

    // R10 / R11 target reached
    run_en = 1'b1;
    step();
    vout_reached = 1'b1;
    repeat (5) step();
    chk(gate_o, "R10 on-phase not cut", gate_o, 1);
    trip_now();
    repeat (BL + 1) step();
    chk(done_o && !gate_o, "R11 done after target", {done_o, gate_o}, 2);
    zc_in = 1'b1;
    seen = 0;
    repeat (40) begin
      step();
      seen |= gate_o;
    end
    chk(!seen, "R10 no cycle at target", seen, 0);
    zc_in = 1'b0;
    vout_reached = 1'b0;
    step();
    chk(gate_o && !done_o, "R11 done cleared on start", {gate_o, done_o}, 2);
    repeat (3) step();
    trip_now();
    repeat (8) step();

    // R10 abort during resonant delay
    op_code = 4'd15;
    zc_in = 1'b1;
    repeat (10) step();
    run_en = 1'b0;
    seen = 0;
    repeat (80) begin
      step();
      seen |= gate_o;
    end
    chk(!seen, "R10 delay abandoned on disable", seen, 0);
    chk(!done_o, "R11 no done on disable", done_o, 0);
    zc_in = 1'b0;
    repeat (3) step();
    summary();
  end

endmodule